// File: doc/BRIEF.md
# Bus Turnaround and Silence Timers

This block gives a fieldbus master two independent down-counting timers for its bus exchanges. The turnaround timer measures the minimum gap the master leaves before it transmits again. The silence timer bounds how long the master waits for a reply, for example after it finishes sending an identification frame, or after a message response ends while a final acknowledgment is still pending. The host programs a length for each timer. The host reads the live counts from the count outputs, and it can use the expired pulses as timeout flags.

Both timers restart from their own programmed lengths whenever a frame event pulse arrives. A frame event is the end of a transmission, a frame received correctly, or a frame received with a CRC error. Each timer also has its own host start input. That input is a level, and only its rising edge restarts the timer. The block carries no data stream, so it has no valid/ready interface. Every pin is a plain control or status signal.

Top module: `bus_gap_timers`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both counts read 0 and both expired outputs read 0.
- R2: A high on any of `tx_done_p`, `rx_ok_p` or `rx_crc_err_p` at a rising clock edge loads `turn_len` into `turn_count` and `sil_len` into `sil_count` at that edge.
- R3: A rising edge on `turn_start` reloads only the turnaround timer, and a rising edge on `sil_start` reloads only the silence timer. The load happens at the first clock edge that samples the level high. Holding the level high causes no further reload, and the other timer is not disturbed.
- R4: When no reload occurs, a nonzero count drops by exactly one per clock. A zero count stays at zero.
- R5: An expired output is high for exactly one cycle. That cycle is the first one in which its count reads 0 after stepping down from 1. Loading a length of 0 produces no expired pulse.
- R6: A reload in the same cycle as the step from 1 to 0 wins. The count takes the new length, and no expired pulse is produced.
- R7: A reload while a timer is still counting restarts it from the newly presented length.
- R8: The length input is sampled only at a reload. Changing it while the timer runs does not alter the running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous core reset, active high |
| tx_done_p | input | 1 | One-cycle pulse when a transmission finishes |
| rx_ok_p | input | 1 | One-cycle pulse when a frame is received correctly |
| rx_crc_err_p | input | 1 | One-cycle pulse when a received frame fails its CRC |
| turn_start | input | 1 | Host start level for the turnaround timer (rising edge acts) |
| sil_start | input | 1 | Host start level for the silence timer (rising edge acts) |
| turn_len | input | CNT_W | Programmed turnaround length in clocks |
| sil_len | input | CNT_W | Programmed silence length in clocks |
| turn_count | output | CNT_W | Live turnaround count |
| sil_count | output | CNT_W | Live silence count |
| turn_expired | output | 1 | One-cycle pulse when the turnaround count reaches zero |
| sil_expired | output | 1 | One-cycle pulse when the silence count reaches zero |

## Verification
Each count is visible on the ports every cycle. A bad load, a skipped step or a missed hold therefore appears on the count output one clock after the edge that caused it. A wrong edge-detector state shows up on the following clock, either as a reload that never happens or as a repeated reload while the start level is held. A faulty expiry flag appears exactly in the cycle where the count first reads zero, or in the cycle where a reload collides with that step.

// File: rtl/bus_gap_timers_pkg.sv
package bus_gap_timers_pkg;
  localparam int NUM_TIMERS = 2;
  localparam int TURN_IDX   = 0;
  localparam int SIL_IDX    = 1;
endpackage

// File: rtl/bgt_rise_pulse.sv
module bgt_rise_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  // one-cycle pulse in the cycle the level is first seen high
  assign pulse_o = level_i & ~prev_q;
endmodule

// File: rtl/bgt_reload_merge.sv
module bgt_reload_merge #(
  parameter int NUM_EVT = 3
) (
  input  logic [NUM_EVT-1:0] frame_evt_i,
  input  logic               host_p_i,
  output logic               reload_o
);
  assign reload_o = (|frame_evt_i) | host_p_i;
endmodule

// File: rtl/bgt_down_timer.sv
module bgt_down_timer #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      exp_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i;
      exp_q <= 1'b0;
    end else begin
      exp_q <= (cnt_q == ONE);
      if (cnt_q != ZERO) cnt_q <= cnt_q - ONE;
    end
  end

  assign count_o   = cnt_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/bus_gap_timers.sv
module bus_gap_timers
  import bus_gap_timers_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_done_p,
  input  logic             rx_ok_p,
  input  logic             rx_crc_err_p,
  input  logic             turn_start,
  input  logic             sil_start,
  input  logic [CNT_W-1:0] turn_len,
  input  logic [CNT_W-1:0] sil_len,
  output logic [CNT_W-1:0] turn_count,
  output logic [CNT_W-1:0] sil_count,
  output logic             turn_expired,
  output logic             sil_expired
);
  localparam int NUM_EVT = 3;

  logic [NUM_EVT-1:0] frame_evt;
  logic [NUM_TIMERS-1:0] start_lvl;
  logic [NUM_TIMERS-1:0] start_p;
  logic [NUM_TIMERS-1:0] reload;
  logic [NUM_TIMERS-1:0] expired;
  logic [CNT_W-1:0]      len_a   [NUM_TIMERS];
  logic [CNT_W-1:0]      count_a [NUM_TIMERS];

  assign frame_evt = {rx_crc_err_p, rx_ok_p, tx_done_p};

  assign start_lvl[TURN_IDX] = turn_start;
  assign start_lvl[SIL_IDX]  = sil_start;
  assign len_a[TURN_IDX]     = turn_len;
  assign len_a[SIL_IDX]      = sil_len;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    bgt_rise_pulse u_edge (
      .clk     (clk),
      .rst     (rst),
      .level_i (start_lvl[t]),
      .pulse_o (start_p[t])
    );

    bgt_reload_merge #(.NUM_EVT(NUM_EVT)) u_merge (
      .frame_evt_i (frame_evt),
      .host_p_i    (start_p[t]),
      .reload_o    (reload[t])
    );

    bgt_down_timer #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .load_i    (reload[t]),
      .len_i     (len_a[t]),
      .count_o   (count_a[t]),
      .expired_o (expired[t])
    );
  end

  assign turn_count   = count_a[TURN_IDX];
  assign sil_count    = count_a[SIL_IDX];
  assign turn_expired = expired[TURN_IDX];
  assign sil_expired  = expired[SIL_IDX];
endmodule

// File: rtl/bus_gap_timers_chk.sv
module bus_gap_timers_chk #(
  parameter int CNT_W = 31
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_done_p,
  input logic             rx_ok_p,
  input logic             rx_crc_err_p,
  input logic             turn_start,
  input logic             sil_start,
  input logic [CNT_W-1:0] turn_len,
  input logic [CNT_W-1:0] sil_len,
  input logic [CNT_W-1:0] turn_count,
  input logic [CNT_W-1:0] sil_count,
  input logic             turn_expired,
  input logic             sil_expired
);
  logic any_evt;
  assign any_evt = tx_done_p | rx_ok_p | rx_crc_err_p;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (turn_count == '0 && sil_count == '0 && !turn_expired && !sil_expired));

  p_frame_reload_r2: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> (turn_count == $past(turn_len) && sil_count == $past(sil_len)));

  p_turn_step_r4: assert property (@(posedge clk) disable iff (rst)
    (turn_count != '0 && !any_evt && !turn_start) |=> turn_count == $past(turn_count) - 1'b1);

  p_sil_step_r4: assert property (@(posedge clk) disable iff (rst)
    (sil_count != '0 && !any_evt && !sil_start) |=> sil_count == $past(sil_count) - 1'b1);

  p_turn_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (turn_count == '0 && !any_evt && !turn_start) |=> turn_count == '0);

  p_turn_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    turn_expired |-> (turn_count == '0 && $past(turn_count) == CNT_W'(1)));

  p_sil_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    sil_expired |-> (sil_count == '0 && $past(sil_count) == CNT_W'(1)));

  p_turn_single_r5: assert property (@(posedge clk) disable iff (rst)
    turn_expired |=> !turn_expired);

  p_reload_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (any_evt && turn_count == CNT_W'(1)) |=> !turn_expired);
endmodule

bind bus_gap_timers bus_gap_timers_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_done_p    (tx_done_p),
  .rx_ok_p      (rx_ok_p),
  .rx_crc_err_p (rx_crc_err_p),
  .turn_start   (turn_start),
  .sil_start    (sil_start),
  .turn_len     (turn_len),
  .sil_len      (sil_len),
  .turn_count   (turn_count),
  .sil_count    (sil_count),
  .turn_expired (turn_expired),
  .sil_expired  (sil_expired)
);

// File: tb/bus_gap_timers_bench.sv
`timescale 1ns/1ps
module bus_gap_timers_bench;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_done_p = 0, rx_ok_p = 0, rx_crc_err_p = 0;
  logic turn_start = 0, sil_start = 0;
  logic [W-1:0] turn_len = '0, sil_len = '0;
  logic [W-1:0] turn_count, sil_count;
  logic turn_expired, sil_expired;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bus_gap_timers #(.CNT_W(W)) u_bus_gap_timers (
    .clk(clk), .rst(rst), .tx_done_p(tx_done_p), .rx_ok_p(rx_ok_p),
    .rx_crc_err_p(rx_crc_err_p), .turn_start(turn_start), .sil_start(sil_start),
    .turn_len(turn_len), .sil_len(sil_len), .turn_count(turn_count),
    .sil_count(sil_count), .turn_expired(turn_expired), .sil_expired(sil_expired)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic frame_pulse(input int src);
    @(negedge clk);
    tx_done_p    = (src == 0);
    rx_ok_p      = (src == 1);
    rx_crc_err_p = (src == 2);
    @(negedge clk);
    tx_done_p = 0; rx_ok_p = 0; rx_crc_err_p = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 turn_count in reset", turn_count, 0);
    chk("R1 sil_count in reset", sil_count, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 turn_count after reset", turn_count, 0);
    chk("R1 sil_expired after reset", sil_expired, 0);

    // R2/R4/R5 sweep: every frame event source, every small length
    for (int src = 0; src < 3; src++) begin
      for (int len = 0; len < 10; len++) begin
        turn_len = W'(len);
        sil_len  = W'(len + 3);
        frame_pulse(src);
        for (int i = 0; i <= len + 5; i++) begin
          chk("R2/R4 turn_count", turn_count, sat(len - i));
          chk("R2/R4 sil_count", sil_count, sat(len + 3 - i));
          chk("R5 turn_expired", turn_expired, (len > 0 && i == len) ? 1 : 0);
          chk("R5 sil_expired", sil_expired, (i == len + 3) ? 1 : 0);
          @(negedge clk);
        end
      end
    end

    // R3: host start per timer, held level, other timer untouched
    for (int t = 0; t < 2; t++) begin
      for (int len = 1; len < 7; len++) begin
        turn_len = W'(len);
        sil_len  = W'(len + 1);
        if (t == 0) turn_start = 1; else sil_start = 1;
        @(negedge clk);
        for (int i = 0; i <= len + 3; i++) begin
          if (t == 0) begin
            chk("R3 turn_count host start held", turn_count, sat(len - i));
            chk("R3 sil_count untouched", sil_count, 0);
          end else begin
            chk("R3 sil_count host start held", sil_count, sat(len + 1 - i));
            chk("R3 turn_count untouched", turn_count, 0);
          end
          @(negedge clk);
        end
        turn_start = 0; sil_start = 0;
        @(negedge clk);
        chk("R3 no reload on falling level turn", turn_count, 0);
        chk("R3 no reload on falling level sil", sil_count, 0);
      end
    end

    // R6: reload collides with the 1 -> 0 step
    turn_len = W'(5);
    turn_start = 1;
    @(negedge clk);
    turn_start = 0;
    repeat (4) @(negedge clk);
    chk("R6 turn_count at one", turn_count, 1);
    turn_len = W'(7);
    rx_ok_p = 1;
    @(negedge clk);
    rx_ok_p = 0;
    chk("R6 reload wins count", turn_count, 7);
    chk("R6 no expiry on collision", turn_expired, 0);
    @(negedge clk);
    chk("R6 no late expiry", turn_expired, 0);
    repeat (8) @(negedge clk);

    // R7: mid-count restart
    turn_len = W'(9);
    frame_pulse(0);
    repeat (3) @(negedge clk);
    chk("R7 count before restart", turn_count, 6);
    turn_len = W'(4);
    frame_pulse(2);
    chk("R7 restarted count", turn_count, 4);
    repeat (6) @(negedge clk);

    // R8: length change during a run has no effect
    sil_len = W'(8);
    frame_pulse(1);
    sil_len = W'(30);
    @(negedge clk);
    chk("R8 running count unaffected", sil_count, 7);
    @(negedge clk);
    chk("R8 running count unaffected later", sil_count, 6);

    // R1: reset mid-count
    rst = 1;
    @(negedge clk);
    chk("R1 mid-count reset turn", turn_count, 0);
    chk("R1 mid-count reset sil", sil_count, 0);
    rst = 0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule